// File: doc/BRIEF.md
# Four-channel converter register front end

This block holds the digital state of a four-channel converter that is loaded over a parallel bus. Every channel keeps a 16-bit output code and a 3-bit range code. Each code is held twice. A staging register takes bus writes. A live register drives the converter core. Software loads the staging registers one at a time. An update moves the code and the range of a channel to the live stage together, so the output never shows a new code paired with an old range.

The bus is bidirectional. A read strobe makes the block drive either the code bus or the range bus with the contents of the addressed register. During a read, the update pin chooses whether the staging stage or the live stage is returned. A strap input selects fixed-range operation. In that mode the live range of every channel is taken from three strap pins, and the range registers are frozen. The write and update strobes are asynchronous to the block clock. Each one passes through a two-flop synchronizer, and the block acts on its rising edge. All bus handshakes are plain strobes, so no back-pressure applies.

Top module: `qdac_regs`

## Requirements
- R1: After reset, every staging and live code register holds 0x8000 and every staging and live range register holds 000.
- R2: A rising edge of wr_n with rd low and sel_span=0 loads data_bus into the staging code register of the addressed channel and leaves every live register unchanged.
- R3: A rising edge of wr_n with rd low and sel_span=1 loads span_bus into the staging range register of the addressed channel, provided fixed_span is low.
- R4: A rising edge of upd with rd low copies the staging code and staging range of the addressed channel into its live registers. The value of sel_span has no effect on this.
- R5: Address codes 0 to 3 select channels A to D, and code 4 applies a write or an update to all four channels. Codes 5 to 7 have no effect on any register.
- R6: While rd is high, wr_n and upd edges change no register.
- R7: While rd is high and the address is 0 to 3, sel_span=0 drives data_bus and sel_span=1 drives span_bus. With upd low the staging register is returned; with upd high the live register is returned.
- R8: data_oe and span_oe are high only while rd is high, and only the bus chosen by sel_span is driven. The other bus stays high-impedance.
- R9: While fixed_span is high, live_span of every channel equals span_strap. Range writes and range updates are ignored, and span_oe stays low. The stored range registers keep their earlier values.
- R10: A high clr at a clock edge returns every register to the reset values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr | input | 1 | Synchronous clear to the reset values |
| wr_n | input | 1 | Active-low write strobe; acts on its rising edge |
| upd | input | 1 | Update strobe; during a read, selects the stage returned |
| rd | input | 1 | Read strobe |
| sel_span | input | 1 | 0 selects the code path, 1 selects the range path |
| addr | input | 3 | Channel address, with 4 meaning all channels |
| fixed_span | input | 1 | Fixed-range strap |
| span_strap | input | 3 | Range used by all channels in fixed-range mode |
| data_bus | inout | 16 | Bidirectional code bus |
| span_bus | inout | 3 | Bidirectional range bus |
| data_oe | output | 1 | The block is driving data_bus |
| span_oe | output | 1 | The block is driving span_bus |
| live_data | output | 64 | Live codes, channel n at bits 16n+15:16n |
| live_span | output | 12 | Live ranges, channel n at bits 3n+2:3n |

## Verification
Each channel is written with a distinct code, so a wrong channel decode shows up as a misplaced value. The live outputs are checked before and after each update, which separates the staging stage from the live stage. The range path of one channel is swept through all eight codes. Updates are issued with sel_span=1 to show that the select has no effect on them. The broadcast address and an unused address are checked against readback of every channel. A combined read, write and update pattern, with different staging and live values, shows whether a write or an update leaks through during a read. Fixed-range and clear sequences are then checked against the register contents saved before them.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned QDAC_NCH = 4;
  localparam int unsigned QDAC_DW  = 16;
  localparam int unsigned QDAC_SW  = 3;
  localparam int unsigned QDAC_AW  = 3;

  typedef enum logic { STAGE_IN = 1'b0, STAGE_LIVE = 1'b1 } stage_e;
endpackage

// File: rtl/qdac_edge_sync.sv
module qdac_edge_sync #(
  parameter bit IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
      s3_q <= IDLE;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic          fixed_i,
  input  logic [SW-1:0] strap_i,
  input  logic          sel_i,
  input  logic          wr_go_i,
  input  logic          upd_go_i,
  input  logic          span_path_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] wspan_i,
  output logic [DW-1:0] din_o,
  output logic [DW-1:0] dlive_o,
  output logic [SW-1:0] sin_o,
  output logic [SW-1:0] slive_o,
  output logic [SW-1:0] span_eff_o
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  logic [DW-1:0] din_q, dlive_q;
  logic [SW-1:0] sin_q, slive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q   <= MID;
      dlive_q <= MID;
      sin_q   <= '0;
      slive_q <= '0;
    end else if (clr_i) begin
      din_q   <= MID;
      dlive_q <= MID;
      sin_q   <= '0;
      slive_q <= '0;
    end else begin
      if (sel_i && wr_go_i && !span_path_i) din_q <= wdata_i;
      if (sel_i && wr_go_i && span_path_i && !fixed_i) sin_q <= wspan_i;
      if (sel_i && upd_go_i) begin
        dlive_q <= din_q;
        if (!fixed_i) slive_q <= sin_q;
      end
    end
  end

  assign din_o      = din_q;
  assign dlive_o    = dlive_q;
  assign sin_o      = sin_q;
  assign slive_o    = slive_q;
  assign span_eff_o = fixed_i ? strap_i : slive_q;

  AST_WR_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go_i && !upd_go_i && !clr_i) |=> $stable(dlive_q) && $stable(slive_q)); // R2
  AST_UPD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && upd_go_i && !clr_i) |=> dlive_q == $past(din_q)); // R4
  AST_RD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !clr_i) |=> $stable(din_q) && $stable(dlive_q) && $stable(sin_q) && $stable(slive_q)); // R6
  AST_FIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_i && !clr_i) |=> $stable(sin_q) && $stable(slive_q)); // R9
  AST_CLR_MID: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (din_q == MID) && (dlive_q == MID) && (sin_q == '0) && (slive_q == '0)); // R10
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int unsigned NCH = QDAC_NCH,
  parameter int unsigned DW  = QDAC_DW,
  parameter int unsigned SW  = QDAC_SW,
  parameter int unsigned AW  = QDAC_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_n,
  input  logic              upd,
  input  logic              rd,
  input  logic              sel_span,
  input  logic [AW-1:0]     addr,
  input  logic              fixed_span,
  input  logic [SW-1:0]     span_strap,
  inout  wire  [DW-1:0]     data_bus,
  inout  wire  [SW-1:0]     span_bus,
  output logic              data_oe,
  output logic              span_oe,
  output logic [NCH*DW-1:0] live_data,
  output logic [NCH*SW-1:0] live_span
);
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] BCAST = AW'(NCH);

  logic wr_rise, upd_rise, wr_go, upd_go;
  logic addr_ok;
  logic [CW-1:0] rd_ch;
  logic [DW-1:0] din_a [NCH];
  logic [DW-1:0] dlive_a [NCH];
  logic [SW-1:0] sin_a [NCH];
  logic [SW-1:0] slive_a [NCH];
  logic [DW-1:0] rdata;
  logic [SW-1:0] rspan;
  stage_e stage;

  qdac_edge_sync #(.IDLE(1'b1)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(wr_n), .rise_o(wr_rise));
  qdac_edge_sync #(.IDLE(1'b0)) u_upd_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(upd), .rise_o(upd_rise));

  assign wr_go  = wr_rise & ~rd;
  assign upd_go = upd_rise & ~rd;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = (addr == AW'(c)) || (addr == BCAST);
    qdac_channel #(.DW(DW), .SW(SW)) u_ch (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .rd_i(rd),
      .fixed_i(fixed_span), .strap_i(span_strap), .sel_i(sel),
      .wr_go_i(wr_go), .upd_go_i(upd_go), .span_path_i(sel_span),
      .wdata_i(data_bus), .wspan_i(span_bus),
      .din_o(din_a[c]), .dlive_o(dlive_a[c]), .sin_o(sin_a[c]), .slive_o(slive_a[c]),
      .span_eff_o(live_span[c*SW +: SW]));
    assign live_data[c*DW +: DW] = dlive_a[c];
  end

  assign addr_ok = (addr < AW'(NCH));
  assign rd_ch   = CW'(addr);
  assign stage   = upd ? STAGE_LIVE : STAGE_IN;
  assign rdata   = (stage == STAGE_LIVE) ? dlive_a[rd_ch] : din_a[rd_ch];
  assign rspan   = (stage == STAGE_LIVE) ? slive_a[rd_ch] : sin_a[rd_ch];

  assign data_oe = rd & addr_ok & ~sel_span;
  assign span_oe = rd & addr_ok & sel_span & ~fixed_span;

  assign data_bus = data_oe ? rdata : 'z;
  assign span_bus = span_oe ? rspan : 'z;

  AST_OE_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe || span_oe) |-> (rd && !(data_oe && span_oe))); // R8
  AST_FIXED_NO_SPAN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_span |-> !span_oe); // R9
endmodule

// File: tb/sim_qdac_regs.sv
module sim_qdac_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, wr_n = 1'b1, upd = 1'b0, rd = 1'b0, sel_span = 1'b0;
  logic [2:0] addr = '0;
  logic fixed_span = 1'b0;
  logic [2:0] span_strap = '0;
  logic tb_den = 1'b0, tb_sen = 1'b0;
  logic [15:0] tb_d = '0;
  logic [2:0] tb_s = '0;
  wire [15:0] data_bus;
  wire [2:0] span_bus;
  logic data_oe, span_oe;
  logic [63:0] live_data;
  logic [11:0] live_span;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int mdi [4], mda [4], msi [4], msa [4];

  always #5 clk = ~clk;

  assign data_bus = tb_den ? tb_d : 'z;
  assign span_bus = tb_sen ? tb_s : 'z;

  qdac_regs u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_n(wr_n), .upd(upd), .rd(rd),
    .sel_span(sel_span), .addr(addr), .fixed_span(fixed_span), .span_strap(span_strap),
    .data_bus(data_bus), .span_bus(span_bus), .data_oe(data_oe), .span_oe(span_oe),
    .live_data(live_data), .live_span(live_span));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      mdi[c] = 32'h8000; mda[c] = 32'h8000; msi[c] = 0; msa[c] = 0;
    end
  endtask

  task automatic do_write(input int a, input bit ds, input int v);
    @(negedge clk);
    addr = 3'(a); sel_span = ds;
    if (ds) begin tb_s = 3'(v); tb_sen = 1'b1; end
    else begin tb_d = 16'(v); tb_den = 1'b1; end
    wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    tb_den = 1'b0; tb_sen = 1'b0;
    for (int c = 0; c < 4; c++)
      if (c == a || a == 4) begin
        if (ds) begin if (!fixed_span) msi[c] = v & 7; end
        else mdi[c] = v & 16'hFFFF;
      end
  endtask

  task automatic do_update(input int a, input bit ds);
    @(negedge clk);
    addr = 3'(a); sel_span = ds; upd = 1'b1;
    repeat (3) @(negedge clk);
    upd = 1'b0;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 4; c++)
      if (c == a || a == 4) begin
        mda[c] = mdi[c];
        if (!fixed_span) msa[c] = msi[c];
      end
  endtask

  task automatic rd_bus(input int a, input bit ds, input bit stg,
                        output int v, output bit doe, output bit soe);
    @(negedge clk);
    rd = 1'b1; addr = 3'(a); sel_span = ds; upd = stg;
    repeat (4) @(negedge clk);
    v = ds ? int'(span_bus) : int'(data_bus);
    doe = data_oe; soe = span_oe;
    upd = 1'b0;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_live(input string tag);
    for (int c = 0; c < 4; c++) begin
      chk(int'(live_data[c*16 +: 16]) == mda[c], tag, int'(live_data[c*16 +: 16]), mda[c]);
      chk(int'(live_span[c*3 +: 3]) == msa[c], tag, int'(live_span[c*3 +: 3]), msa[c]);
    end
  endtask

  task automatic check_read_all(input string tag);
    int v; bit doe, soe;
    for (int c = 0; c < 4; c++) begin
      rd_bus(c, 1'b0, 1'b0, v, doe, soe);
      chk(v == mdi[c] && doe && !soe, tag, v, mdi[c]);
      rd_bus(c, 1'b0, 1'b1, v, doe, soe);
      chk(v == mda[c], tag, v, mda[c]);
      rd_bus(c, 1'b1, 1'b0, v, doe, soe);
      chk(v == msi[c] && soe && !doe, tag, v, msi[c]);
      rd_bus(c, 1'b1, 1'b1, v, doe, soe);
      chk(v == msa[c], tag, v, msa[c]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v; bit doe, soe;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check_live("R1 reset live");
    check_read_all("R1 reset readback");
    chk(!data_oe && !span_oe, "R8 idle enables", {data_oe, span_oe}, 0);

    for (int c = 0; c < 4; c++) begin
      do_write(c, 1'b0, 16'hA5C3 ^ (c * 16'h1111));
      do_write(c, 1'b1, (c + 3) & 7);
      check_live("R2 live untouched by write");
      do_update(c, 1'b1);
      check_live("R4 update copies both");
    end
    check_read_all("R7 readback per channel");

    for (int s = 0; s < 8; s++) begin
      do_write(2, 1'b1, s);
      rd_bus(2, 1'b1, 1'b0, v, doe, soe);
      chk(v == s, "R3 span staging", v, s);
      do_update(2, 1'b0);
      chk(int'(live_span[6 +: 3]) == s, "R3 span live", int'(live_span[6 +: 3]), s);
    end

    do_write(4, 1'b0, 16'h0F0F);
    do_write(4, 1'b1, 6);
    do_update(4, 1'b0);
    check_live("R5 broadcast");
    do_write(5, 1'b0, 16'h1234);
    do_write(7, 1'b1, 1);
    do_update(6, 1'b0);
    check_read_all("R5 unused address");

    do_write(1, 1'b0, 16'hBEEF);
    @(negedge clk);
    rd = 1'b1; addr = 3'd1; sel_span = 1'b0; upd = 1'b1;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    upd = 1'b0;
    @(negedge clk);
    rd = 1'b0;
    repeat (2) @(negedge clk);
    check_live("R6 read blocks update");
    rd_bus(1, 1'b0, 1'b0, v, doe, soe);
    chk(v == 16'hBEEF, "R6 read blocks write", v, 16'hBEEF);

    @(negedge clk);
    fixed_span = 1'b1; span_strap = 3'd5;
    @(negedge clk);
    for (int c = 0; c < 4; c++)
      chk(int'(live_span[c*3 +: 3]) == 5, "R9 strap span", int'(live_span[c*3 +: 3]), 5);
    do_write(0, 1'b1, 2);
    do_update(0, 1'b1);
    chk(int'(live_data[15:0]) == mda[0], "R9 data still updates", int'(live_data[15:0]), mda[0]);
    rd_bus(0, 1'b1, 1'b0, v, doe, soe);
    chk(!soe && !doe, "R9 span readback off", {doe, soe}, 0);
    @(negedge clk);
    fixed_span = 1'b0;
    @(negedge clk);
    check_live("R9 span regs kept");
    check_read_all("R9 span staging kept");

    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_reset();
    @(negedge clk);
    check_live("R10 clear live");
    check_read_all("R10 clear readback");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule